// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a small in-order integer core. It has five stages: fetch, decode with register read, execute, data memory access and write-back. An explicit register sits at each stage boundary and carries a valid bit, the control bits and the operands. Each stage reads the register upstream of it and fills the one downstream.

The core has no hazard detection, no forwarding and no stalls. Software must place independent instructions or no-ops between a producer and its consumers. A taken branch discards the two younger instructions already in flight.

The instruction memory is loaded through a write port while reset is held. Debug read ports expose the register file and the data memory, so that results can be observed after a program halts. Execution stops when a halt instruction reaches fetch. The `done` flag rises once that halt has retired.

Top module: `pipe5_core`

## Requirements
- R1: While `rst` is high at a clock edge, the PC is cleared to 0, every pipeline valid bit is cleared, all eight registers are cleared and `done` is cleared.
- R2: With no taken branch and no halt in fetch, the PC advances by one instruction per cycle. Instructions retire in program order.
- R3: The instruction word is 16 bits wide, with these fields:
  - opcode in [15:13]: 0 no-op, 1 add, 2 load, 3 store, 4 branch-if-equal, 5 add-immediate, 6 no-op, 7 halt;
  - regA in [12:10];
  - regB in [9:7];
  - add destination in [6:4];
  - signed 7-bit immediate in [6:0].

  Add writes regA + regB, modulo 2^16, into the destination.
- R4: Add-immediate writes regA + sign-extended immediate into regB.
- R5: Load writes into regB the data memory word at the low 6 bits of regA + sign-extended immediate.
- R6: Store writes regB into the data memory word at the low 6 bits of regA + sign-extended immediate.
- R7: A branch whose regA and regB are equal sets the next PC to its own PC + 1 + immediate. The two instructions that follow it do not execute.
- R8: A branch whose regA and regB differ has no effect. The following instructions execute.
- R9: Register 0 always reads as zero, and writes to it are ignored.
- R10: A result written back is visible to an instruction placed three slots after its producer (write-before-read in the same cycle).
- R11: A halt in fetch holds the PC. Older instructions still complete, instructions after the halt never execute, and `done` rises and stays high once the halt has retired.
- R12: Opcode 6 changes no register and no memory word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_we | input | 1 | Instruction memory write enable |
| imem_waddr | input | IMEM_AW | Instruction memory write address |
| imem_wdata | input | 16 | Instruction word to write |
| dbg_reg_sel | input | 3 | Register index for debug read |
| dbg_reg_data | output | XLEN | Contents of the selected register |
| dbg_mem_addr | input | DMEM_AW | Data memory address for debug read |
| dbg_mem_data | output | XLEN | Contents of the selected data word |
| done | output | 1 | A halt instruction has retired |

## Verification
The assertions assume several things about the inputs:
- the instruction memory is written only while reset is held;
- programs never read a register fewer than three slots after the instruction that writes it;
- every branch target lies inside the program.

The stimulus respects all of these. Each program is loaded entirely under reset. Its dependent instructions are spaced exactly three slots apart, or padded with no-ops or with unrelated instructions where needed. Its forward and backward branches land only on loaded words, and the rest of the instruction memory is filled with halts.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
  localparam int ILEN   = 16;
  localparam int OPW    = 3;
  localparam int REG_AW = 3;
  localparam int IMMW   = 7;
  localparam int OP_LSB = ILEN - OPW;
  localparam int RA_LSB = OP_LSB - REG_AW;
  localparam int RB_LSB = RA_LSB - REG_AW;
  localparam int RD_LSB = IMMW - REG_AW;

  typedef enum logic [OPW-1:0] {
    OP_NOP  = 3'd0,
    OP_ADD  = 3'd1,
    OP_LW   = 3'd2,
    OP_SW   = 3'd3,
    OP_BEQ  = 3'd4,
    OP_ADDI = 3'd5,
    OP_RSV  = 3'd6,
    OP_HALT = 3'd7
  } op_e;

  typedef struct packed {
    logic use_imm;
    logic is_branch;
    logic mem_rd;
    logic mem_wr;
    logic reg_we;
    logic dest_is_b;
    logic is_halt;
  } ctrl_t;

  typedef struct packed {
    logic use_imm;
    logic is_branch;
    logic mem_rd;
    logic mem_wr;
    logic reg_we;
    logic is_halt;
  } ex_ctrl_t;

  typedef struct packed {
    logic mem_rd;
    logic mem_wr;
    logic reg_we;
    logic is_halt;
  } mem_ctrl_t;

  typedef struct packed {
    logic reg_we;
    logic from_mem;
    logic is_halt;
  } wb_ctrl_t;

  function automatic ctrl_t decode_op(input logic [OPW-1:0] op);
    ctrl_t c;
    c = '0;
    case (op_e'(op))
      OP_ADD:  c.reg_we = 1'b1;
      OP_ADDI: begin c.reg_we = 1'b1; c.use_imm = 1'b1; c.dest_is_b = 1'b1; end
      OP_LW:   begin c.reg_we = 1'b1; c.use_imm = 1'b1; c.dest_is_b = 1'b1; c.mem_rd = 1'b1; end
      OP_SW:   begin c.use_imm = 1'b1; c.mem_wr = 1'b1; end
      OP_BEQ:  c.is_branch = 1'b1;
      OP_HALT: c.is_halt = 1'b1;
      default: c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
  parameter int XLEN = 16,
  parameter int AW   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   ra_a,
  input  logic [AW-1:0]   ra_b,
  output logic [XLEN-1:0] rd_a,
  output logic [XLEN-1:0] rd_b,
  input  logic [AW-1:0]   dbg_sel,
  output logic [XLEN-1:0] dbg_data,
  input  logic            we,
  input  logic [AW-1:0]   wa,
  input  logic [XLEN-1:0] wd
);
  localparam int NREG = 1 << AW;

  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  // write-before-read: a same-cycle write is visible to the decode read
  always_comb begin
    if (ra_a == '0)                rd_a = '0;
    else if (we && wa == ra_a)     rd_a = wd;
    else                           rd_a = regs[ra_a];
    if (ra_b == '0)                rd_b = '0;
    else if (we && wa == ra_b)     rd_b = wd;
    else                           rd_b = regs[ra_b];
  end

  assign dbg_data = (dbg_sel == '0) ? '0 : regs[dbg_sel];
endmodule

// File: rtl/pipe5_imem.sv
module pipe5_imem #(
  parameter int W  = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pipe5_dmem.sv
module pipe5_dmem #(
  parameter int W  = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  input  logic [AW-1:0] dbg_addr,
  output logic [W-1:0]  dbg_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata     = mem[addr];
  assign dbg_rdata = mem[dbg_addr];
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int XLEN    = 16,
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               imem_we,
  input  logic [IMEM_AW-1:0] imem_waddr,
  input  logic [ILEN-1:0]    imem_wdata,
  input  logic [REG_AW-1:0]  dbg_reg_sel,
  output logic [XLEN-1:0]    dbg_reg_data,
  input  logic [DMEM_AW-1:0] dbg_mem_addr,
  output logic [XLEN-1:0]    dbg_mem_data,
  output logic               done
);
  localparam int PCW = IMEM_AW;

  // ---------------- fetch ----------------
  logic [PCW-1:0]  pc, pc_plus1, pc_next;
  logic [ILEN-1:0] fetch_instr;
  logic            fetch_halt;
  logic            ex_taken;
  logic [PCW-1:0]  ex_target;

  pipe5_imem #(.W(ILEN), .AW(IMEM_AW)) u_imem (
    .clk(clk), .we(imem_we), .waddr(imem_waddr), .wdata(imem_wdata),
    .raddr(pc), .rdata(fetch_instr)
  );

  assign pc_plus1   = pc + PCW'(1);
  assign fetch_halt = (op_e'(fetch_instr[OP_LSB +: OPW]) == OP_HALT);

  always_comb begin
    if (ex_taken)        pc_next = ex_target;
    else if (fetch_halt) pc_next = pc;
    else                 pc_next = pc_plus1;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  // ---------------- IF/ID ----------------
  logic            ifid_valid;
  logic [ILEN-1:0] ifid_instr;
  logic [PCW-1:0]  ifid_pc1;

  always_ff @(posedge clk) begin
    if (rst) ifid_valid <= 1'b0;
    else     ifid_valid <= !ex_taken;
  end

  always_ff @(posedge clk) begin
    ifid_instr <= fetch_instr;
    ifid_pc1   <= pc_plus1;
  end

  // ---------------- decode ----------------
  logic [REG_AW-1:0] id_ra, id_rb, id_rd, id_dest;
  logic [XLEN-1:0]   id_a, id_b, id_imm;
  ctrl_t             id_ctrl;
  logic              rf_we;
  logic [REG_AW-1:0] rf_wa;
  logic [XLEN-1:0]   rf_wd;

  assign id_ra   = ifid_instr[RA_LSB +: REG_AW];
  assign id_rb   = ifid_instr[RB_LSB +: REG_AW];
  assign id_rd   = ifid_instr[RD_LSB +: REG_AW];
  assign id_imm  = {{(XLEN-IMMW){ifid_instr[IMMW-1]}}, ifid_instr[IMMW-1:0]};
  assign id_ctrl = decode_op(ifid_instr[OP_LSB +: OPW]);
  assign id_dest = id_ctrl.dest_is_b ? id_rb : id_rd;

  pipe5_regfile #(.XLEN(XLEN), .AW(REG_AW)) u_rf (
    .clk(clk), .rst(rst),
    .ra_a(id_ra), .ra_b(id_rb), .rd_a(id_a), .rd_b(id_b),
    .dbg_sel(dbg_reg_sel), .dbg_data(dbg_reg_data),
    .we(rf_we), .wa(rf_wa), .wd(rf_wd)
  );

  // ---------------- ID/EX ----------------
  logic              idex_valid;
  ex_ctrl_t          idex_ctrl;
  logic [XLEN-1:0]   idex_a, idex_b, idex_imm;
  logic [PCW-1:0]    idex_pc1;
  logic [REG_AW-1:0] idex_dest;

  always_ff @(posedge clk) begin
    if (rst) idex_valid <= 1'b0;
    else     idex_valid <= ifid_valid && !ex_taken;
  end

  always_ff @(posedge clk) begin
    idex_ctrl <= '{use_imm: id_ctrl.use_imm, is_branch: id_ctrl.is_branch,
                   mem_rd: id_ctrl.mem_rd, mem_wr: id_ctrl.mem_wr,
                   reg_we: id_ctrl.reg_we, is_halt: id_ctrl.is_halt};
    idex_a    <= id_a;
    idex_b    <= id_b;
    idex_imm  <= id_imm;
    idex_pc1  <= ifid_pc1;
    idex_dest <= id_dest;
  end

  // ---------------- execute ----------------
  logic [XLEN-1:0] ex_opb, ex_alu;

  assign ex_opb    = idex_ctrl.use_imm ? idex_imm : idex_b;
  assign ex_alu    = idex_a + ex_opb;
  assign ex_taken  = idex_valid && idex_ctrl.is_branch && (idex_a == idex_b);
  assign ex_target = idex_pc1 + idex_imm[PCW-1:0];

  // ---------------- EX/MEM ----------------
  logic              exmem_valid;
  mem_ctrl_t         exmem_ctrl;
  logic [XLEN-1:0]   exmem_alu, exmem_st;
  logic [REG_AW-1:0] exmem_dest;

  always_ff @(posedge clk) begin
    if (rst) exmem_valid <= 1'b0;
    else     exmem_valid <= idex_valid;
  end

  always_ff @(posedge clk) begin
    exmem_ctrl <= '{mem_rd: idex_ctrl.mem_rd, mem_wr: idex_ctrl.mem_wr,
                    reg_we: idex_ctrl.reg_we, is_halt: idex_ctrl.is_halt};
    exmem_alu  <= ex_alu;
    exmem_st   <= idex_b;
    exmem_dest <= idex_dest;
  end

  // ---------------- memory ----------------
  logic            dmem_we;
  logic [XLEN-1:0] mem_ld;

  assign dmem_we = exmem_valid && exmem_ctrl.mem_wr;

  pipe5_dmem #(.W(XLEN), .AW(DMEM_AW)) u_dmem (
    .clk(clk), .we(dmem_we), .addr(exmem_alu[DMEM_AW-1:0]),
    .wdata(exmem_st), .rdata(mem_ld),
    .dbg_addr(dbg_mem_addr), .dbg_rdata(dbg_mem_data)
  );

  // ---------------- MEM/WB ----------------
  logic              memwb_valid;
  wb_ctrl_t          memwb_ctrl;
  logic [XLEN-1:0]   memwb_alu, memwb_ld;
  logic [REG_AW-1:0] memwb_dest;

  always_ff @(posedge clk) begin
    if (rst) memwb_valid <= 1'b0;
    else     memwb_valid <= exmem_valid;
  end

  always_ff @(posedge clk) begin
    memwb_ctrl <= '{reg_we: exmem_ctrl.reg_we, from_mem: exmem_ctrl.mem_rd,
                    is_halt: exmem_ctrl.is_halt};
    memwb_alu  <= exmem_alu;
    memwb_ld   <= mem_ld;
    memwb_dest <= exmem_dest;
  end

  // ---------------- write-back ----------------
  assign rf_we = memwb_valid && memwb_ctrl.reg_we;
  assign rf_wa = memwb_dest;
  assign rf_wd = memwb_ctrl.from_mem ? memwb_ld : memwb_alu;

  always_ff @(posedge clk) begin
    if (rst)                                   done <= 1'b0;
    else if (memwb_valid && memwb_ctrl.is_halt) done <= 1'b1;
  end
endmodule

// File: rtl/pipe5_chk.sv
module pipe5_chk #(
  parameter int PCW = 6
) (
  input logic           clk,
  input logic           rst,
  input logic [PCW-1:0] pc,
  input logic [PCW-1:0] ex_target,
  input logic           ex_taken,
  input logic           fetch_halt,
  input logic           ifid_valid,
  input logic           idex_valid,
  input logic           exmem_valid,
  input logic           memwb_valid,
  input logic           rf_we,
  input logic           done
);
  logic rst_q = 1'b0;

  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk) begin
    if (rst_q) begin
      AST_RESET_EMPTY: assert (pc == '0 && !ifid_valid && !idex_valid && !exmem_valid
                               && !memwb_valid && !done)
        else $error("pipeline not empty after reset"); // R1
    end
  end

  AST_PC_INCR: assert property (@(posedge clk) disable iff (rst)
    (!ex_taken && !fetch_halt) |=> pc == $past(pc) + PCW'(1)); // R2

  AST_WB_ORDER: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> $past(exmem_valid)); // R2

  AST_BRANCH_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    ex_taken |=> (pc == $past(ex_target) && !ifid_valid && !idex_valid)); // R7

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (fetch_halt && !ex_taken) |=> pc == $past(pc)); // R11

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> done); // R11
endmodule

bind pipe5_core pipe5_chk #(.PCW(IMEM_AW)) u_chk (
  .clk(clk), .rst(rst), .pc(pc), .ex_target(ex_target), .ex_taken(ex_taken),
  .fetch_halt(fetch_halt), .ifid_valid(ifid_valid), .idex_valid(idex_valid),
  .exmem_valid(exmem_valid), .memwb_valid(memwb_valid), .rf_we(rf_we), .done(done)
);

// File: tb/test_pipe5_core.sv
`timescale 1ns/1ps
module test_pipe5_core;
  localparam int XLEN    = 16;
  localparam int IMEM_AW = 6;
  localparam int DMEM_AW = 6;
  localparam int DEPTH   = 1 << IMEM_AW;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               imem_we = 1'b0;
  logic [IMEM_AW-1:0] imem_waddr = '0;
  logic [15:0]        imem_wdata = '0;
  logic [2:0]         dbg_reg_sel = '0;
  logic [XLEN-1:0]    dbg_reg_data;
  logic [DMEM_AW-1:0] dbg_mem_addr = '0;
  logic [XLEN-1:0]    dbg_mem_data;
  logic               done;

  int          n_chk = 0;
  int          n_bad = 0;
  int          cyc = 0;
  bit          finished = 1'b0;
  logic [15:0] prog [DEPTH];

  always #2.5 clk = ~clk;

  pipe5_core #(.XLEN(XLEN), .IMEM_AW(IMEM_AW), .DMEM_AW(DMEM_AW)) i_pipe5_core (
    .clk(clk), .rst(rst), .imem_we(imem_we), .imem_waddr(imem_waddr),
    .imem_wdata(imem_wdata), .dbg_reg_sel(dbg_reg_sel), .dbg_reg_data(dbg_reg_data),
    .dbg_mem_addr(dbg_mem_addr), .dbg_mem_data(dbg_mem_data), .done(done)
  );

  function automatic logic [15:0] enc(int op, int ra, int rb, int low7);
    return {op[2:0], ra[2:0], rb[2:0], low7[6:0]};
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd_reg(int r, output logic [15:0] v);
    dbg_reg_sel = r[2:0];
    #1;
    v = dbg_reg_data;
  endtask

  task automatic rd_mem(int a, output logic [15:0] v);
    dbg_mem_addr = a[DMEM_AW-1:0];
    #1;
    v = dbg_mem_data;
  endtask

  // load under reset, check reset state, run until done
  task automatic run_prog();
    logic [15:0] v;
    bit ok;
    rst = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      imem_we    = 1'b1;
      imem_waddr = i[IMEM_AW-1:0];
      imem_wdata = prog[i];
    end
    @(negedge clk);
    imem_we = 1'b0;
    check("R1 done low in reset", {15'd0, done}, 16'd0);
    for (int r = 0; r < 8; r++) begin
      rd_reg(r, v);
      check("R1 register cleared", v, 16'd0);
    end
    @(negedge clk);
    rst = 1'b0;
    ok = 1'b0;
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
    check("R11 halt retired", {15'd0, ok}, 16'd1);
    repeat (3) @(negedge clk);
    check("R11 done stays high", {15'd0, done}, 16'd1);
  endtask

  task automatic main_prog(int a, int b);
    logic [15:0] v, ea, eb, esum;
    int addr;
    for (int i = 0; i < DEPTH; i++) prog[i] = enc(7, 0, 0, 0);
    prog[0]  = enc(5, 0, 1, a);
    prog[1]  = enc(5, 0, 2, b);
    prog[2]  = enc(5, 0, 0, 5);
    prog[3]  = enc(6, 1, 1, 5);
    prog[4]  = enc(1, 1, 2, 3 << 4);
    prog[5]  = enc(1, 1, 1, 5 << 4);
    prog[6]  = 16'h0000;
    prog[7]  = enc(3, 1, 3, 5);
    prog[8]  = enc(2, 1, 6, 5);
    prog[9]  = enc(4, 1, 1, 2);
    prog[10] = enc(5, 0, 5, 7);
    prog[11] = enc(5, 0, 5, 7);
    prog[12] = enc(4, 1, 2, 1);
    prog[13] = enc(5, 0, 4, 3);
    prog[14] = enc(1, 6, 0, 7 << 4);
    prog[15] = enc(7, 0, 0, 0);
    prog[16] = enc(5, 0, 6, 9);
    run_prog();
    ea   = 16'(a);
    eb   = 16'(b);
    esum = ea + eb;
    addr = (a + 5) & ((1 << DMEM_AW) - 1);
    rd_reg(0, v); check("R9 r0 write ignored", v, 16'd0);
    rd_reg(1, v); check("R4 R12 addi r1", v, ea);
    rd_reg(2, v); check("R4 addi r2", v, eb);
    rd_reg(3, v); check("R3 R10 add r3", v, esum);
    rd_reg(4, v); check(a == b ? "R7 beq taken skips" : "R8 beq not taken", v, a == b ? 16'd0 : 16'd3);
    rd_reg(5, v); check("R7 branch shadow flushed", v, ea + ea);
    rd_reg(6, v); check("R5 R11 load word, post-halt ignored", v, esum);
    rd_reg(7, v); check("R9 R2 add with r0", v, esum);
    rd_mem(addr, v); check("R6 store word", v, esum);
  endtask

  task automatic loop_prog(int n);
    logic [15:0] v;
    for (int i = 0; i < DEPTH; i++) prog[i] = enc(7, 0, 0, 0);
    prog[0]  = enc(5, 0, 1, n);
    prog[1]  = enc(5, 0, 2, -1);
    prog[2]  = enc(5, 0, 3, 0);
    prog[3]  = 16'h0000;
    prog[4]  = enc(1, 1, 2, 1 << 4);
    prog[5]  = enc(5, 3, 3, 1);
    prog[6]  = 16'h0000;
    prog[7]  = enc(4, 1, 0, 2);
    prog[8]  = enc(4, 0, 0, -5);
    prog[9]  = enc(5, 0, 4, 1);
    prog[10] = enc(7, 0, 0, 0);
    run_prog();
    rd_reg(1, v); check("R7 loop counter exhausted", v, 16'd0);
    rd_reg(3, v); check("R7 backward branch iterations", v, 16'(n));
    rd_reg(4, v); check("R7 shadow of loop exit flushed", v, 16'd0);
    rd_reg(2, v); check("R4 negative immediate", v, 16'hFFFF);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      finished = 1'b1;
      n_bad++;
      $display("FAIL watchdog R11 actual=running expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int vals [14] = '{-64, -50, -37, -20, -9, -1, 0, 1, 2, 7, 19, 33, 48, 63};
    foreach (vals[i]) begin
      foreach (vals[j]) main_prog(vals[i], vals[j]);
    end
    for (int n = 1; n <= 16; n++) loop_prog(n);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule